// File: doc/BRIEF.md
# Cascaded 16-bit Programmable Pulse Generator

This block produces a pulse train on one output pin from a 16-bit up counter. The counter is built from two byte-wide halves. Software programs the pulse period and the point inside it where the pin switches. Each value is 16 bits wide and is loaded one byte at a time through a small write port. The pin rests at an idle level that software selects. The counter counts up from zero. When it reaches the duty value, the pin flips to the opposite level. When it reaches the period value, the pin returns to its idle level and the counter clears. Each of these two events raises a one-clock interrupt pulse.

Counting advances only on a count-enable tick. The tick comes either from an internal prescaler tick input or from rising edges of an external clock pin, which is synchronized inside the block. New settings take effect through a commit step: writing the duty high byte moves all four byte registers at once. With buffering off, the commit reaches the active compare values directly. With buffering on, it goes to a holding buffer. The buffer then moves into the active values at the next period match, or at once if the timer is stopped.

Top module: `ppg16_timer`

## Requirements
- R1: The write port uses these addresses: 0 = period low byte, 1 = period high byte, 2 = duty low byte, 3 = duty high byte. Writes to addresses 0, 1 and 2 only stage a byte and leave the running waveform unchanged. A write to address 3 commits all four bytes together.
- R2: While `run` is 1, the counter advances by one per count-enable tick and compares its current value before incrementing. With period value P, the waveform repeats every P+1 ticks.
- R3: On the tick where the counter equals the duty value D, and D < P, the pin changes to the inverse of the idle level and `duty_irq` pulses high for exactly one clock.
- R4: On the tick where the counter equals P, the counter clears to zero, the pin returns to the idle level and `period_irq` pulses high for exactly one clock.
- R5: `init_level` sets the idle level: 0 means low and 1 means high. With `init_level` = 1, the whole waveform is inverted.
- R6: While `run` is 0, the counter holds at zero, the pin shows the idle level and neither interrupt fires. Clearing `run` mid-period therefore restarts the next run from count zero.
- R7: With `dbuf_en` = 0, a commit updates the active period and duty in the same edge. Compares from the next tick onward use the new values.
- R8: With `dbuf_en` = 1 and `run` = 1, committed values wait in the buffer. They become active at the next period match, so the current period completes with the old values.
- R9: With `dbuf_en` = 1 and `run` = 0, buffered values become active in the cycle after the commit.
- R10: If D >= P, no duty match occurs. The pin stays at the idle level and `duty_irq` never fires, but period matches still clear the counter and pulse `period_irq`.
- R11: With `ext_sel` = 1, ticks come only from rising edges of `ext_clk` after a two-flop synchronizer, and `int_tick` is ignored. With `ext_sel` = 0, ticks come from `int_tick` and `ext_clk` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Byte register select (0 period lo, 1 period hi, 2 duty lo, 3 duty hi + commit) |
| wr_data | input | 8 | Byte write data |
| run | input | 1 | Counter enable; 0 stops and clears |
| dbuf_en | input | 1 | Route commits through the holding buffer |
| init_level | input | 1 | Idle pin level |
| ext_sel | input | 1 | 1 selects external clock edges as the tick source |
| int_tick | input | 1 | Internal prescaler count-enable tick |
| ext_clk | input | 1 | Asynchronous external clock input |
| pwm_out | output | 1 | Pulse output pin |
| duty_irq | output | 1 | One-clock pulse on duty match |
| period_irq | output | 1 | One-clock pulse on period match |

## Verification
The assertions assume that `init_level` is held steady while the timer runs. They also assume that the two interrupt outputs are never requested on the same tick, which follows from a duty match requiring D < P. The stimulus changes `init_level` and `dbuf_en` only while `run` is 0. It holds `int_tick` high so that every clock is a tick, which makes the expected waveform a simple function of the cycle index. On the external clock path, `ext_clk` is kept high and low for several clocks at a time, so every edge passes through the synchronizer.

// File: rtl/ppg16_timer.sv
module ppg16_timer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              run,
  input  logic              dbuf_en,
  input  logic              init_level,
  input  logic              ext_sel,
  input  logic              int_tick,
  input  logic              ext_clk,
  output logic              pwm_out,
  output logic              duty_irq,
  output logic              period_irq
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] per_lo, per_hi, duty_lo;
  logic [CNT_W-1:0]  buf_per, buf_duty, act_per, act_duty, cnt_q;
  logic              buf_pend, out_q, dirq_q, pirq_q;
  logic [2:0]        ext_s;

  wire ext_rise = ext_s[1] & ~ext_s[2];
  wire tick     = ext_sel ? ext_rise : int_tick;
  wire commit   = wr_en && (wr_addr == 2'd3);
  wire [CNT_W-1:0] new_per  = {per_hi, per_lo};
  wire [CNT_W-1:0] new_duty = {wr_data, duty_lo};
  wire pmatch = run && tick && (cnt_q == act_per);
  wire dmatch = run && tick && (cnt_q == act_duty) && (act_duty < act_per);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_s <= '0;
    else        ext_s <= {ext_s[1:0], ext_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per_lo  <= '0;
      per_hi  <= '0;
      duty_lo <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: per_lo  <= wr_data;
        2'd1: per_hi  <= wr_data;
        2'd2: duty_lo <= wr_data;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      buf_per  <= '0;
      buf_duty <= '0;
      buf_pend <= 1'b0;
      act_per  <= '0;
      act_duty <= '0;
    end else begin
      if (buf_pend && (!run || pmatch)) begin
        act_per  <= buf_per;
        act_duty <= buf_duty;
        buf_pend <= 1'b0;
      end
      if (commit) begin
        if (dbuf_en) begin
          buf_per  <= new_per;
          buf_duty <= new_duty;
          buf_pend <= 1'b1;
        end else begin
          act_per  <= new_per;
          act_duty <= new_duty;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      out_q  <= 1'b0;
      dirq_q <= 1'b0;
      pirq_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      out_q  <= init_level;
      dirq_q <= 1'b0;
      pirq_q <= 1'b0;
    end else begin
      dirq_q <= dmatch;
      pirq_q <= pmatch;
      if (pmatch) begin
        cnt_q <= '0;
        out_q <= init_level;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
        if (dmatch) out_q <= ~init_level;
      end
    end

  assign pwm_out    = out_q;
  assign duty_irq   = dirq_q;
  assign period_irq = pirq_q;

  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0) && !duty_irq && !period_irq);

  // R4
  period_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_irq |-> (cnt_q == '0) && (pwm_out == init_level));

  // R3
  duty_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty_irq |-> (cnt_q == $past(act_duty) + 1'b1) && (pwm_out != init_level));

  // R10
  irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({duty_irq, period_irq}));

  // R2
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));

  // R8
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_pend && run && !pmatch && !commit) |=> buf_pend);
endmodule

// File: tb/ppg16_timer_tb.sv
module ppg16_timer_tb;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, run = 0, dbuf_en = 0, init_level = 0, ext_sel = 0;
  logic int_tick = 1, ext_clk = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic pwm_out, duty_irq, period_irq;
  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  ppg16_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .dbuf_en(dbuf_en), .init_level(init_level), .ext_sel(ext_sel),
    .int_tick(int_tick), .ext_clk(ext_clk), .pwm_out(pwm_out),
    .duty_irq(duty_irq), .period_irq(period_irq));

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] model(int i, int p, int d, logic lvl);
    int ph = i % (p + 1);
    logic act = (d < p) && ph >= d && ph < p;
    return {lvl ^ act, (d < p) && ph == d, ph == p};
  endfunction

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load(int p, int d);
    wr(2'd0, p[7:0]); wr(2'd1, p[15:8]); wr(2'd2, d[7:0]); wr(2'd3, d[15:8]);
  endtask

  task automatic stop();
    @(negedge clk); run = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wave(string req, int p, int d, int n);
    @(negedge clk); run = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, {pwm_out, duty_irq, period_irq}, model(i, p, d, init_level));
    end
  endtask

  task automatic t_reset();
    check("R6 reset", {pwm_out, duty_irq, period_irq}, 3'b000);
  endtask

  task automatic t_basic();
    load(5, 2); wave("R2 R3 R4 basic", 5, 2, 14); stop();
    load(300, 4); wave("R2 R1 high byte", 300, 4, 310); stop();
    load(4, 0); wave("R3 duty zero", 4, 0, 12); stop();
  endtask

  task automatic t_polarity();
    init_level = 1;
    load(6, 3); wave("R5 inverted", 6, 3, 16); stop();
    check("R5 idle high", {pwm_out, duty_irq, period_irq}, 3'b100);
    init_level = 0;
    repeat (2) @(negedge clk);
    check("R5 idle low", {pwm_out, duty_irq, period_irq}, 3'b000);
  endtask

  task automatic t_staging();
    load(5, 2);
    wr(2'd0, 8'd1); wr(2'd1, 8'd0); wr(2'd2, 8'd0);
    wave("R1 staged only", 5, 2, 14); stop();
    wr(2'd3, 8'd0);
    wave("R1 commit", 1, 0, 8); stop();
  endtask

  task automatic t_stop();
    load(9, 3); wave("R6 pre-stop", 9, 3, 6);
    @(negedge clk); run = 0;
    @(negedge clk);
    check("R6 stop idle", {pwm_out, duty_irq, period_irq}, 3'b000);
    wave("R6 restart from zero", 9, 3, 12); stop();
  endtask

  task automatic t_nomatch();
    load(3, 3); wave("R10 duty equals period", 3, 3, 9); stop();
    load(3, 5); wave("R10 duty above period", 3, 5, 9); stop();
  endtask

  task automatic t_update(logic db);
    int sw = db ? 8 : 4;
    dbuf_en = 0; load(3, 1); dbuf_en = db;
    @(negedge clk); run = 1;
    for (int i = 0; i < 22; i++) begin
      logic [2:0] e;
      @(negedge clk);
      e = (i < sw) ? model(i, 3, 1, 0) : model(i - sw, 6, 4, 0);
      check(db ? "R8 buffered update" : "R7 direct update", {pwm_out, duty_irq, period_irq}, e);
      wr_en = (i < 4);
      wr_addr = i[1:0];
      wr_data = (i == 0) ? 8'd6 : (i == 2) ? 8'd4 : 8'd0;
    end
    wr_en = 0;
    stop(); dbuf_en = 0;
  endtask

  task automatic t_buf_stopped();
    dbuf_en = 1; load(4, 2);
    wave("R9 buffer while stopped", 4, 2, 10); stop();
    dbuf_en = 0;
  endtask

  task automatic t_ext();
    int np = 0, nd = 0;
    load(2, 1);
    ext_sel = 1; int_tick = 1;
    repeat (4) @(negedge clk);
    run = 1;
    for (int k = 0; k < 9; k++) begin
      ext_clk = 1;
      repeat (3) begin @(negedge clk); np += period_irq; nd += duty_irq; end
      ext_clk = 0;
      repeat (3) begin @(negedge clk); np += period_irq; nd += duty_irq; end
    end
    repeat (6) begin @(negedge clk); np += period_irq; nd += duty_irq; end
    check("R11 ext edges", {1'b0, np[1:0]}, 3'b011);
    check("R11 ext duty", {1'b0, nd[1:0]}, 3'b011);
    np = 0;
    repeat (20) begin @(negedge clk); np += period_irq + duty_irq; end
    check("R11 int_tick ignored", np[2:0], 3'b000);
    ext_sel = 0; int_tick = 0;
    for (int k = 0; k < 6; k++) begin
      ext_clk = ~ext_clk;
      repeat (3) begin @(negedge clk); np += period_irq + duty_irq; end
    end
    check("R11 ext_clk ignored", np[2:0], 3'b000);
    stop(); int_tick = 1; ext_clk = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_polarity();
    t_staging();
    t_stop();
    t_nomatch();
    t_update(1'b0);
    t_update(1'b1);
    t_buf_stopped();
    t_ext();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule